// File: doc/BRIEF.md
# Reloading Interval Timer with Prescaled Readback

This block is a periodic countdown timer that sits inside a processor core. Software programs a 7-bit period value and a run bit through a two-location write window selected by a single address bit. While running, a 17-bit internal counter steps down once per tick-enable pulse. The tick-enable pulse comes from the core's clock divider. When the counter expires, it reloads from the programmed period and keeps going. Each expiry also raises an interrupt request, which stays latched until the interrupt controller pulses an acknowledge.

A read returns a coarse view of the counter, the top seven bits of the 17-bit count. Bit 7 of the read data repeats bit 7 of the last byte written to either timer location. The counter holds the remaining ticks minus one, so a freshly started timer reads back its own period value. A full period is exactly (period value + 1) × 1024 ticks.

Top module: `interval_timer`

## Requirements
- R1: After reset the timer is stopped, `irq_req` is 0, `rd_data` reads 0x00, and the period value is 127. A start without any period write therefore reads back 0x7F in bits 6:0.
- R2: A write with `wr_addr`=0 stores `wr_data[6:0]` as the period value P. The interval between expiries is then (P+1)×1024 ticks.
- R3: A write with `wr_addr`=1 sets the run bit from `wr_data[0]`. A change from stopped to running loads the counter to (P+1)×1024−1, so an immediate read gives P in bits 6:0.
- R4: Writing run=1 while the timer is already running leaves the counter unchanged.
- R5: The counter decreases by one only at clock edges where `tick_en` is 1 and the timer is running. While the timer is stopped, or while `tick_en` is 0, the counter holds its value.
- R6: On the tick that expires the counter, the counter reloads from the period value and `irq_req` is set at the same edge. The timer keeps running, so successive expiries are one full period apart.
- R7: `irq_req` stays 1 until an edge with `irq_ack`=1 clears it. An expiry and an ack at the same edge leave `irq_req` at 1.
- R8: `rd_data[6:0]` equals counter bits 16:10. Between reloads this value never increases.
- R9: Every write, at either address, stores the whole byte as the last I/O byte. `rd_data[7]` is bit 7 of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-enable pulse from the core prescaler |
| wr_en | input | 1 | Write strobe for the timer window |
| wr_addr | input | 1 | 0 selects the period value, 1 selects the run bit |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Last I/O byte bit 7 followed by counter bits 16:10 |
| irq_ack | input | 1 | Acknowledge pulse that clears the interrupt request |
| irq_req | output | 1 | Latched timer interrupt request |

## Verification
Two situations are hard to reach from the ports. One is an acknowledge that arrives on the very edge where the counter expires. The other is a measurement of the longest period, 131072 ticks. For the first, the stimulus counts ticks from a known start and places the ack pulse on the 1024th tick of a minimum-period run. For the second, it starts the timer with the reset period value and holds `tick_en` high until the request appears. The tick-gating check measures expiry in ticks rather than cycles while `tick_en` toggles from `$urandom`. A slow-period run tracks the read value every cycle to check that it never rises between reloads.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  // Window offsets; the address bit selects which register a write targets.
  typedef enum logic {
    OFS_PERIOD = 1'b0,
    OFS_RUN    = 1'b1
  } itmr_ofs_e;
endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
  import itmr_pkg::*;
#(
  parameter int PRE_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PRE_W-1:0]  preload_q,
  output logic              run_q,
  output logic [DATA_W-1:0] io_q,
  output logic              start_o
);
  logic              wr_period, wr_run;
  logic [PRE_W-1:0]  preload_d;
  logic              run_d;
  logic [DATA_W-1:0] io_d;

  always_comb begin
    wr_period = wr_en && (itmr_ofs_e'(wr_addr) == OFS_PERIOD);
    wr_run    = wr_en && (itmr_ofs_e'(wr_addr) == OFS_RUN);
    preload_d = wr_period ? wr_data[PRE_W-1:0] : preload_q;
    run_d     = wr_run ? wr_data[0] : run_q;
    io_d      = wr_en ? wr_data : io_q;
    start_o   = wr_run && wr_data[0] && !run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload_q <= '1;
      run_q     <= 1'b0;
      io_q      <= '0;
    end else begin
      preload_q <= preload_d;
      run_q     <= run_d;
      io_q      <= io_d;
    end
  end

  // R9: every write lands in the last-byte register
  a_r9_io_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> io_q == $past(wr_data));
  // R2: the period value changes only through a write at offset 0
  a_r2_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_addr) |=> $stable(preload_q));
endmodule

// File: rtl/itmr_count.sv
module itmr_count #(
  parameter int PRE_W = 7,
  parameter int SHIFT = 10,
  localparam int CNT_W = PRE_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run_q,
  input  logic             load_i,
  input  logic [PRE_W-1:0] preload,
  output logic [CNT_W-1:0] count_q,
  output logic             expire_o
);
  logic [CNT_W-1:0] period_m1;
  logic [CNT_W-1:0] count_d;
  logic             step;

  always_comb begin
    period_m1 = {preload, {SHIFT{1'b1}}};
    step      = run_q && tick_en && !load_i;
    expire_o  = step && (count_q == '0);
    if (load_i)        count_d = period_m1;
    else if (expire_o) count_d = period_m1;
    else if (step)     count_d = count_q - CNT_W'(1);
    else               count_d = count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  // R5: no tick, no movement
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !(run_q && tick_en)) |=> $stable(count_q));
  // R5: a running tick lowers the count by exactly one
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && run_q && tick_en && count_q != '0) |=> count_q == $past(count_q) - CNT_W'(1));
  // R6: expiry reloads the full period
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> count_q == {$past(preload), {SHIFT{1'b1}}});
endmodule

// File: rtl/itmr_irq.sv
module itmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic ack_i,
  output logic irq_q
);
  logic irq_d;

  always_comb irq_d = expire_i || (irq_q && !ack_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  // R7: the request is sticky until acknowledged
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ack_i) |=> irq_q);
  // R7: an expiry wins over a coincident ack
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> irq_q);
  // R7: an ack with no expiry clears it
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !expire_i) |=> !irq_q);
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int PRE_W  = 7,
  parameter int SHIFT  = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              irq_ack,
  output logic              irq_req
);
  localparam int CNT_W = PRE_W + SHIFT;

  logic [PRE_W-1:0]  preload_q;
  logic              run_q;
  logic [DATA_W-1:0] io_q;
  logic              start;
  logic [CNT_W-1:0]  count_q;
  logic              expire;

  itmr_regs #(.PRE_W(PRE_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .preload_q (preload_q),
    .run_q     (run_q),
    .io_q      (io_q),
    .start_o   (start)
  );

  itmr_count #(.PRE_W(PRE_W), .SHIFT(SHIFT)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .run_q    (run_q),
    .load_i   (start),
    .preload  (preload_q),
    .count_q  (count_q),
    .expire_o (expire)
  );

  itmr_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire_i (expire),
    .ack_i    (irq_ack),
    .irq_q    (irq_req)
  );

  always_comb begin
    rd_data = '0;
    rd_data[DATA_W-1]  = io_q[DATA_W-1];
    rd_data[PRE_W-1:0] = count_q[CNT_W-1 -: PRE_W];
  end

  // R4: a run write while running never reloads
  a_r4_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && wr_en && wr_addr && wr_data[0] && !tick_en) |=> $stable(count_q));
endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       irq_ack = 1'b0;
  logic [7:0] rd_data;
  logic       irq_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  interval_timer u_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  function automatic int period_ticks(input int p);
    return (p + 1) * 1024;
  endfunction

  function automatic logic [7:0] start_view(input logic [7:0] last, input int p);
    return {last[7], 7'(p)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // count ticks with tick_en always high until irq_req rises; returns cycles
  task automatic run_until_irq(output int n);
    n = 0;
    tick_en = 1'b1;
    while (!irq_req && n < 140000) begin
      @(negedge clk);
      n++;
    end
    tick_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, ticks, prev, seed;
    logic [7:0] v, b;
    seed = $urandom(32'h1bad5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 rd_data", rd_data, 0);
    check("R1 irq_req", irq_req, 0);
    wr(1'b1, 8'h01);
    check("R1 default period view", rd_data[6:0], 127);
    // R1/R2: longest period measured from start
    run_until_irq(n);
    check("R2 interval preload 127", n, period_ticks(127));
    check("R6 reload after expiry", rd_data[6:0], 127);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    check("R7 ack clears", irq_req, 0);
    wr(1'b1, 8'h00);

    // R3/R9: random period writes, start, read back
    for (int i = 0; i < 20; i++) begin
      int p;
      p = $urandom_range(0, 127);
      b = 8'($urandom);
      wr(1'b0, {b[7], 7'(p)});
      wr(1'b1, {b[6], 6'($urandom), 1'b1});
      v = start_view({b[6], 7'h0}, p);
      check("R3 start loads period", rd_data, v);
      check("R9 bit7 from last write", rd_data[7], b[6]);
      wr(1'b1, {b[5], 7'h00});
      check("R9 stop write updates bit7", rd_data[7], b[5]);
    end

    // R5: stopped timer ignores ticks
    wr(1'b0, 8'h05);
    wr(1'b1, 8'h01);
    tick_en = 1'b1; repeat (2048) @(negedge clk); tick_en = 1'b0;
    check("R5 running ticks lower view", rd_data[6:0], 3);
    wr(1'b1, 8'h00);
    tick_en = 1'b1; repeat (3000) @(negedge clk); tick_en = 1'b0;
    check("R5 stopped holds", rd_data[6:0], 3);
    // R4: re-enable while running keeps count; stop->start reloads
    wr(1'b1, 8'h01);
    check("R3 restart reloads", rd_data[6:0], 5);
    tick_en = 1'b1; repeat (1500) @(negedge clk); tick_en = 1'b0;
    v = rd_data;
    wr(1'b1, 8'h01);
    check("R4 no reload while running", rd_data[6:0], v[6:0]);
    wr(1'b1, 8'h00);

    // R5: gated ticks, preload 0, measure in ticks
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h01);
    ticks = 0;
    while (!irq_req && ticks < 5000) begin
      tick_en = 1'($urandom);
      @(posedge clk);
      if (tick_en) ticks++;
      @(negedge clk);
    end
    tick_en = 1'b0;
    check("R5 gated interval in ticks", ticks, period_ticks(0));
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;

    // R7: ack at the expiry edge; periodic second interval preload 0
    tick_en = 1'b1;
    repeat (1023) @(negedge clk);
    check("R6 no early irq", irq_req, 0);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0; tick_en = 1'b0;
    check("R7 expiry beats ack", irq_req, 1);
    repeat (10) @(negedge clk);
    check("R7 held without ack", irq_req, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    wr(1'b1, 8'h00);

    // R8/R6: preload 3, monotonic view, two periodic intervals
    wr(1'b0, 8'h03);
    wr(1'b1, 8'h01);
    for (int k = 0; k < 2; k++) begin
      int bad;
      bad = 0; n = 0;
      prev = rd_data[6:0];
      tick_en = 1'b1;
      while (!irq_req && n < 10000) begin
        @(negedge clk);
        n++;
        if (!irq_req && rd_data[6:0] > prev) bad++;
        prev = rd_data[6:0];
      end
      tick_en = 1'b0;
      check("R8 view never rises", bad, 0);
      check("R6 periodic interval preload 3", n, period_ticks(3));
      check("R8 view after reload", rd_data[6:0], 3);
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule